// File: doc/BRIEF.md
# Parallel ADC Read Sequencer

This block runs one conversion on an external converter with a byte-wide parallel interface, from the host side. A start request in idle drives the active-low convert strobe low for a minimum pulse. The block then waits for the converter's busy flag to rise and then fall. After that it reads the result in two strobed byte reads, upper byte first, with chip-select held across both reads. The two bytes are joined into a 10-bit word and given out with a one-cycle valid pulse. A guard interval follows before the next conversion may start.

Every analog-side delay is a nanosecond parameter. It is turned into a whole number of cycles of the system clock, always rounded up. An optional wake-up step serves a converter left in power-down. In that step the block first pulses the strobe, then waits the power-up time, and only then issues the real convert pulse. If busy never rises, or stays high past the conversion limit plus a margin, the block pulses an error flag and goes back to idle without reading.

Top module: `adc_rd_seq`

## Requirements
- R1: After reset the convert, chip-select and read strobes are all high (inactive), and both the valid and error outputs are low.
- R2: A start request in idle drives `adc_cnv_n` low for exactly 3 cycles at the default 125 MHz (20 ns rounded up to whole 8 ns cycles).
- R3: If busy is not seen high, the error output pulses for one cycle exactly 10 cycles after the convert strobe fell. Those 10 cycles are the 3-cycle pulse plus a 7-cycle window: 30 ns rounded up to 4 cycles, plus 2 synchronizer stages, plus 1. No read takes place, and the block returns to idle.
- R4: If busy rises but stays high, the error output pulses for one cycle no sooner than 288 cycles (2.3 µs) after the convert strobe fell, and no read takes place.
- R5: Once busy has fallen, two reads follow. For each one, `adc_rd_n` is low for exactly 2 cycles (10 ns rounded up), and `adc_cs_n` is low in every cycle in which `adc_rd_n` is low. The data bus is sampled in the last cycle of each low phase.
- R6: Between the upper-byte read and the lower-byte read, `adc_rd_n` stays high for exactly 2 cycles.
- R7: `result` equals {first byte bits [1:0], second byte bits [7:0]}. It is qualified by `result_valid`, which is high for exactly one cycle per conversion.
- R8: The next falling edge of `adc_cnv_n` comes at least 7 cycles (50 ns) after the rising edge of the read strobe. With start held high, it comes exactly 8 cycles after that edge.
- R9: With `wake_en` high at start, a 3-cycle wake pulse is issued first. `adc_cnv_n` then stays high for exactly 188 cycles (1.5 µs) before the 3-cycle convert pulse.
- R10: Start requests that arrive while a sequence is in progress are ignored. Each accepted start produces exactly one convert pulse, or two with wake-up.
- R11: Every delay count is ceil(ns × CLK_HZ / 1e9) cycles, never less than one.
- R12: `adc_cnv_n` is never low while `adc_rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken only in idle |
| wake_en | input | 1 | Issue a wake pulse and power-up wait first |
| adc_busy | input | 1 | Converter busy flag (asynchronous) |
| adc_db | input | 8 | Converter data bus |
| adc_cnv_n | output | 1 | Active-low convert strobe |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_rd_n | output | 1 | Active-low read strobe |
| result | output | 10 | Assembled conversion result |
| result_valid | output | 1 | One-cycle result qualifier |
| timeout_err | output | 1 | One-cycle busy timeout flag |

## Verification
The hardest states to reach are the two busy timeouts and the guard interval between back-to-back conversions, because a well-behaved converter never leads there. The bench uses a cycle-based converter model with switches that suppress the busy rise or hold busy high. It also holds start high across two conversions so that the guard gap is measured right at its minimum. The model puts a fill value on the bus during the first cycle of each read, so sampling the bus too early shows up as a wrong result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE_P, S_WAKE_W, S_CNV, S_WAIT_R,
    S_WAIT_F, S_RD_HI, S_GAP, S_RD_LO, S_GUARD
  } seq_state_t;

  // ceil(ns * hz / 1e9), at least one cycle
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_seq_assemble.sv
module adc_seq_assemble #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_cap,
  input  logic             lo_cap,
  input  logic [BUS_W-1:0] db,
  output logic [RES_W-1:0] result,
  output logic             valid
);
  logic [BUS_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      hi_q <= '0;
    else if (hi_cap) hi_q <= db;

  generate
    if (RES_W > BUS_W) begin : g_split
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      result <= '0;
        else if (lo_cap) result <= {hi_q[RES_W-BUS_W-1:0], db};
    end else begin : g_low_only
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      result <= '0;
        else if (lo_cap) result <= db[RES_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) valid <= 1'b0;
    else        valid <= lo_cap;
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned RES_W       = 10,
  parameter int unsigned PULSE_NS    = 20,
  parameter int unsigned RISE_NS     = 30,
  parameter int unsigned CONV_NS     = 2300,
  parameter int unsigned WAKE_NS     = 1500,
  parameter int unsigned ACCESS_NS   = 10,
  parameter int unsigned GAP_NS      = 10,
  parameter int unsigned GUARD_NS    = 50,
  parameter int unsigned FALL_MARGIN = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wake_en,
  input  logic             adc_busy,
  input  logic [BUS_W-1:0] adc_db,
  output logic             adc_cnv_n,
  output logic             adc_cs_n,
  output logic             adc_rd_n,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             timeout_err
);
  localparam int unsigned PULSE_CYC = ns_to_cyc(64'(PULSE_NS), 64'(CLK_HZ));
  localparam int unsigned RISE_LIM  = ns_to_cyc(64'(RISE_NS), 64'(CLK_HZ)) + SYNC_STAGES + 1;
  localparam int unsigned FALL_LIM  = ns_to_cyc(64'(CONV_NS), 64'(CLK_HZ)) + FALL_MARGIN + SYNC_STAGES;
  localparam int unsigned WAKE_CYC  = ns_to_cyc(64'(WAKE_NS), 64'(CLK_HZ));
  localparam int unsigned ACC_CYC   = ns_to_cyc(64'(ACCESS_NS), 64'(CLK_HZ));
  localparam int unsigned GAP_CYC   = ns_to_cyc(64'(GAP_NS), 64'(CLK_HZ));
  localparam int unsigned GUARD_CYC = ns_to_cyc(64'(GUARD_NS), 64'(CLK_HZ));
  localparam int unsigned MAX_CYC   = max2(max2(max2(PULSE_CYC, RISE_LIM), max2(FALL_LIM, WAKE_CYC)),
                                           max2(max2(ACC_CYC, GAP_CYC), GUARD_CYC));
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  seq_state_t     st, nxt;
  logic           busy_s;
  logic           tmr_load, tmr_exp;
  logic [TW-1:0]  tmr_val;
  logic           to_err;
  logic           err_q;

  // named internal events
  logic hi_cap, lo_cap;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_busy), .q(busy_s)
  );

  adc_seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    to_err   = 1'b0;
    unique case (st)
      S_IDLE:   if (start) begin
                  tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1);
                  nxt = wake_en ? S_WAKE_P : S_CNV;
                end
      S_WAKE_P: if (tmr_exp) begin
                  tmr_load = 1'b1; tmr_val = TW'(WAKE_CYC - 1); nxt = S_WAKE_W;
                end
      S_WAKE_W: if (tmr_exp) begin
                  tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1); nxt = S_CNV;
                end
      S_CNV:    if (tmr_exp) begin
                  tmr_load = 1'b1; tmr_val = TW'(RISE_LIM - 1); nxt = S_WAIT_R;
                end
      S_WAIT_R: if (busy_s) begin
                  tmr_load = 1'b1; tmr_val = TW'(FALL_LIM - 1); nxt = S_WAIT_F;
                end else if (tmr_exp) begin
                  to_err = 1'b1; nxt = S_IDLE;
                end
      S_WAIT_F: if (!busy_s) begin
                  tmr_load = 1'b1; tmr_val = TW'(ACC_CYC - 1); nxt = S_RD_HI;
                end else if (tmr_exp) begin
                  to_err = 1'b1; nxt = S_IDLE;
                end
      S_RD_HI:  if (tmr_exp) begin
                  tmr_load = 1'b1; tmr_val = TW'(GAP_CYC - 1); nxt = S_GAP;
                end
      S_GAP:    if (tmr_exp) begin
                  tmr_load = 1'b1; tmr_val = TW'(ACC_CYC - 1); nxt = S_RD_LO;
                end
      S_RD_LO:  if (tmr_exp) begin
                  tmr_load = 1'b1; tmr_val = TW'(GUARD_CYC - 1); nxt = S_GUARD;
                end
      S_GUARD:  if (tmr_exp) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      err_q <= 1'b0;
    end else begin
      st    <= nxt;
      err_q <= to_err;
    end

  assign hi_cap = (st == S_RD_HI) && tmr_exp;
  assign lo_cap = (st == S_RD_LO) && tmr_exp;

  adc_seq_assemble #(.BUS_W(BUS_W), .RES_W(RES_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .hi_cap(hi_cap), .lo_cap(lo_cap),
    .db(adc_db), .result(result), .valid(result_valid)
  );

  assign adc_cnv_n   = !((st == S_CNV) || (st == S_WAKE_P));
  assign adc_rd_n    = !((st == S_RD_HI) || (st == S_RD_LO));
  assign adc_cs_n    = !((st == S_RD_HI) || (st == S_GAP) || (st == S_RD_LO));
  assign timeout_err = err_q;
endmodule

// File: rtl/adc_rd_seq_chk.sv
module adc_rd_seq_chk #(
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned GUARD_CYC = 7
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_n,
  input logic cs_n,
  input logic rd_n,
  input logic res_valid,
  input logic err,
  input logic hi_cap,
  input logic lo_cap
);
  logic [15:0] lo_run;
  logic [15:0] since_rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    lo_run <= '0;
    else if (!cnv_n)               lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1;
    else                           lo_run <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    since_rd <= 16'hFFFF;
    else if (!rd_n)                since_rd <= '0;
    else if (since_rd != 16'hFFFF) since_rd <= since_rd + 1'b1;

  // R2
  cnv_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n) |-> (lo_run >= 16'(PULSE_CYC)));

  // R5
  cs_covers_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  // R6
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cap |=> !lo_cap);

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cap |=> res_valid);

  // R3
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R8
  guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> (since_rd >= 16'(GUARD_CYC)));

  // R12
  no_cnv_during_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> cnv_n);
endmodule

bind adc_rd_seq adc_rd_seq_chk #(.PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnv_n(adc_cnv_n), .cs_n(adc_cs_n), .rd_n(adc_rd_n),
  .res_valid(result_valid), .err(timeout_err), .hi_cap(hi_cap), .lo_cap(lo_cap)
);

// File: tb/adc_rd_seq_tb_top.sv
module adc_rd_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wake_en = 1'b0;
  logic adc_busy;
  logic [7:0] adc_db;
  logic adc_cnv_n, adc_cs_n, adc_rd_n, result_valid, timeout_err;
  logic [9:0] result;

  always #4 clk = ~clk;  // 125 MHz

  adc_rd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wake_en(wake_en),
    .adc_busy(adc_busy), .adc_db(adc_db), .adc_cnv_n(adc_cnv_n),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .result(result),
    .result_valid(result_valid), .timeout_err(timeout_err)
  );

  // R11: own rounding at 125 MHz (8 ns per cycle)
  function automatic int cyc(input int ns);
    return (ns * 125 + 999) / 1000;
  endfunction
  function automatic int exp_res(input logic [7:0] hi, input logic [7:0] lo);
    return (int'(hi) % 4) * 256 + int'(lo);
  endfunction

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // converter model
  logic [7:0] hi_m = 8'h00, lo_m = 8'h00;
  int rise_m = 1, conv_m = 50, skip_at = -1;
  bit no_rise_m = 0, stuck_m = 0;
  logic busy_m = 1'b0;
  logic p_cnv_m = 1'b1, p_rd_m = 1'b1;
  bit rd_idx_m = 0;
  int rdlow_m = 0, m_cnt = 0, m_ph = 0, m_falls = 0;

  always @(posedge clk) begin
    p_cnv_m <= adc_cnv_n;
    p_rd_m  <= adc_rd_n;
    rdlow_m <= adc_rd_n ? 0 : rdlow_m + 1;
    if (adc_rd_n && !p_rd_m) rd_idx_m <= !rd_idx_m;
    if (p_cnv_m && !adc_cnv_n) begin
      rd_idx_m <= 0;
      m_falls  <= m_falls + 1;
      if (m_falls != skip_at && !no_rise_m) begin
        m_ph <= 1; m_cnt <= rise_m;
      end
    end else if (m_ph == 1) begin
      if (m_cnt == 0) begin busy_m <= 1'b1; m_ph <= 2; m_cnt <= conv_m; end
      else m_cnt <= m_cnt - 1;
    end else if (m_ph == 2 && !stuck_m) begin
      if (m_cnt == 0) begin busy_m <= 1'b0; m_ph <= 0; end
      else m_cnt <= m_cnt - 1;
    end
  end

  assign adc_busy = busy_m;
  assign adc_db = (!adc_rd_n && rdlow_m >= 1) ? (rd_idx_m ? lo_m : hi_m) : 8'hA5;

  // monitor, sampled away from the active edge
  logic p_cnv = 1'b1, p_rd = 1'b1, p_val = 1'b0;
  int cnv_lo_run = 0, cnv_hi_run = 0, rd_lo_run = 0, rd_hi_run = 0;
  int last_cnv_lo = 0, last_cnv_hi = 0, last_rd_lo = 0, last_rd_hi = 0;
  int since_rd = 0, since_cf = 0, gap_rd_cnv = 0, err_at = 0;
  int cnv_falls = 0, rd_falls = 0, valid_cnt = 0, err_cnt = 0, valid_long = 0;
  int cs_viol = 0, cnv_viol = 0;
  logic [9:0] last_res = '0;

  always @(negedge clk) if (rst_n) begin
    if (!adc_cnv_n) cnv_lo_run++;
    else            cnv_hi_run++;
    if (adc_cnv_n && !p_cnv) begin last_cnv_lo = cnv_lo_run; cnv_lo_run = 0; end
    if (!adc_rd_n) rd_lo_run++;
    else           rd_hi_run++;
    if (adc_rd_n && !p_rd) begin last_rd_lo = rd_lo_run; rd_lo_run = 0; since_rd = 0; end
    else since_rd++;
    if (!adc_rd_n && p_rd) begin last_rd_hi = rd_hi_run; rd_hi_run = 0; rd_falls++; end
    if (!adc_cnv_n && p_cnv) begin
      last_cnv_hi = cnv_hi_run; cnv_hi_run = 0; gap_rd_cnv = since_rd;
      since_cf = 0; cnv_falls++;
    end else since_cf++;
    if (timeout_err) begin err_cnt++; err_at = since_cf; end
    if (result_valid) begin valid_cnt++; last_res = result; end
    if (result_valid && p_val) valid_long++;
    if (!adc_rd_n && adc_cs_n) cs_viol++;
    if (!adc_rd_n && !adc_cnv_n) cnv_viol++;
    p_cnv = adc_cnv_n; p_rd = adc_rd_n; p_val = result_valid;
  end

  task automatic wait_cnt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_conv(input bit wk, input logic [7:0] hi, input logic [7:0] lo,
                          input int rdly, input int clen, input bit poke);
    int v0, f0, vl0, t;
    hi_m = hi; lo_m = lo; rise_m = rdly; conv_m = clen;
    skip_at = wk ? m_falls : -1;
    v0 = valid_cnt; f0 = cnv_falls; vl0 = valid_long;
    @(negedge clk); wake_en = wk; start = 1'b1;
    @(negedge clk); start = 1'b0; wake_en = 1'b0;
    t = 0;
    while (valid_cnt == v0 && t < 3000) begin
      @(negedge clk); t++;
      if (poke && (t == 5 || t == 40 || t == 120)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    wait_cnt(cyc(50) + 3);
    check(valid_cnt == v0 + 1, "R7 valid count", valid_cnt - v0, 1);
    check(int'(last_res) == exp_res(hi, lo), "R7 result", int'(last_res), exp_res(hi, lo));
    check(valid_long == vl0, "R7 valid width", valid_long - vl0, 0);
    check(last_cnv_lo == cyc(20), "R2/R11 convert pulse", last_cnv_lo, cyc(20));
    check(last_rd_lo == cyc(10), "R5 read low", last_rd_lo, cyc(10));
    check(last_rd_hi == cyc(10), "R6 read gap", last_rd_hi, cyc(10));
    check(cnv_falls - f0 == (wk ? 2 : 1), "R10 pulses per start", cnv_falls - f0, wk ? 2 : 1);
    if (wk) check(last_cnv_hi == cyc(1500), "R9 wake wait", last_cnv_hi, cyc(1500));
  endtask

  initial begin
    int v0, r0, e0, t;
    void'($urandom(32'h5EED_1234));
    wait_cnt(3);
    // R1
    check(adc_cnv_n && adc_cs_n && adc_rd_n, "R1 strobes in reset",
          {adc_cnv_n, adc_cs_n, adc_rd_n}, 7);
    check(!result_valid && !timeout_err, "R1 flags in reset",
          {result_valid, timeout_err}, 0);
    rst_n = 1'b1;
    wait_cnt(3);
    check(adc_cnv_n && adc_cs_n && adc_rd_n, "R1 idle strobes",
          {adc_cnv_n, adc_cs_n, adc_rd_n}, 7);

    // directed corners: extreme bytes, slowest busy rise, short/long conversions
    run_conv(1'b0, 8'hFF, 8'hFF, 3, 2, 1'b0);
    run_conv(1'b0, 8'h00, 8'h00, 0, 280, 1'b1);
    run_conv(1'b0, 8'hFE, 8'h01, 1, 100, 1'b0);
    run_conv(1'b1, 8'h02, 8'h80, 2, 60, 1'b1);   // R9

    // random traffic
    for (int i = 0; i < 20; i++) begin
      run_conv(($urandom % 5) == 0, 8'($urandom), 8'($urandom),
               int'($urandom % 4), 10 + int'($urandom % 270), ($urandom % 2) == 1);
    end

    // R8: start held high across two conversions
    hi_m = 8'h03; lo_m = 8'h3C; rise_m = 1; conv_m = 30; skip_at = -1;
    v0 = valid_cnt;
    @(negedge clk); start = 1'b1;
    t = 0;
    while (valid_cnt < v0 + 2 && t < 3000) begin
      @(negedge clk); t++;
      if (valid_cnt == v0 + 1 && !adc_cnv_n) start = 1'b0;
    end
    start = 1'b0;
    check(gap_rd_cnv == cyc(50) + 1, "R8 guard gap", gap_rd_cnv, cyc(50) + 1);
    check(valid_cnt == v0 + 2, "R8 back to back results", valid_cnt - v0, 2);
    wait_cnt(12);

    // R3: busy never rises
    no_rise_m = 1; e0 = err_cnt; r0 = rd_falls;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    wait_cnt(40);
    check(err_cnt == e0 + 1, "R3 error pulse", err_cnt - e0, 1);
    check(err_at == cyc(20) + cyc(30) + 3, "R3 error timing", err_at, cyc(20) + cyc(30) + 3);
    check(rd_falls == r0, "R3 no read", rd_falls - r0, 0);
    check(adc_cnv_n && adc_cs_n && adc_rd_n, "R3 back to idle", {adc_cnv_n, adc_cs_n, adc_rd_n}, 7);
    no_rise_m = 0;
    wait_cnt(5);

    // R4: busy stuck high
    stuck_m = 1; rise_m = 0; conv_m = 2; e0 = err_cnt; r0 = rd_falls;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    wait_cnt(400);
    check(err_cnt == e0 + 1, "R4 error pulse", err_cnt - e0, 1);
    check(err_at >= cyc(2300) && err_at <= cyc(2300) + 40, "R4 error timing", err_at, cyc(2300));
    check(rd_falls == r0, "R4 no read", rd_falls - r0, 0);
    stuck_m = 0;
    wait_cnt(20);

    // recovery after timeouts
    run_conv(1'b0, 8'h01, 8'h55, 2, 40, 1'b0);

    // R5 / R12
    check(cs_viol == 0, "R5 chip-select during read", cs_viol, 0);
    check(cnv_viol == 0, "R12 convert during read", cnv_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule